// File: doc/BRIEF.md
# Power and Thermal Health Status Word

This block watches the health of a processor clock domain on behalf of a clock governor. Every clock it takes one supply voltage sample (in millivolts), one die temperature sample (in tenths of a degree Celsius) and a throttling-active indication. It compares the samples against fixed limits set by parameters and publishes the result as a registered 20-bit status word.

The low four bits are live flags. They report under-voltage, a capped core frequency, active clock throttling and an engaged soft temperature limit. Bits 16 to 19 hold the latched copies of those four flags. A latched flag is set whenever its live condition is seen and stays set until software pulses the clear strobe. The clear strobe touches only the latched flags.

A temperature above the hot limit counts as over-temperature. It forces both the frequency-cap flag and the throttling flag on, whatever the throttling input says. The block does no clock scaling itself and has no sensor interface.

Top module: `thermal_status_word`

## Requirements
- R1: While reset is asserted, and on the first output after reset, all 20 bits of the status word are 0.
- R2: Bit 0 is 1 exactly when the sampled supply is strictly below 4640 mV. At 4640 mV it is 0.
- R3: Bit 1 is 1 when the sampled temperature is strictly above 800 (80.0 °C). At 800 it is 0, unless R5 applies.
- R4: Bit 2 is 1 whenever the throttling-active input is 1.
- R5: A temperature strictly above 850 (85.0 °C) forces both bit 1 and bit 2 to 1. At 850, bit 2 follows only the throttling input.
- R6: Bit 3 is 1 exactly when the sampled temperature is strictly above 700 (70.0 °C). At 700 it is 0.
- R7: Bits 4 to 15 always read 0.
- R8: Bits 16, 17, 18 and 19 latch bits 0, 1, 2 and 3. Each latched bit is set in the same cycle as its live bit and stays 1 after the live condition goes away.
- R9: A clear strobe sampled at a clock edge makes bits 16 to 19 all 0 after that edge and leaves bits 0 to 3 unaffected. A latched bit whose condition is still active is set again at the following edge.
- R10: The inputs are sampled at a rising clock edge. The status word changes only after that edge, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supply_mv | input | 16 | Supply voltage sample in millivolts |
| die_temp_dc | input | 12 | Die temperature sample in tenths of a degree Celsius |
| throttle_req | input | 1 | Clock throttling is active |
| sticky_clr | input | 1 | Clears the latched flags (bits 16 to 19) |
| status_word | output | 20 | Live flags in bits 3:0, zeros in bits 15:4, latched flags in bits 19:16 |

## Verification
The bench drives every limit exactly at its value and one step past it: 4640/4639 mV, and temperatures of 700/701, 800/801 and 850/851. A design that used non-strict comparisons would raise a flag one step too early, and one that mixed up the cap and hot limits would raise the throttling flag at 80.1 °C. The bench asserts the clear strobe while a condition is still present. A design that also cleared the live flags, or that failed to re-latch on the next edge, would show the wrong bits in the two cycles after the strobe. The bench also sets every latched flag and then returns to benign inputs. A design that let a latched flag follow its live bit would then drop bits 16 to 19.

// File: rtl/thermal_status_pkg.sv
package thermal_status_pkg;
   localparam int FLAG_COUNT = 4;
   localparam int STICKY_LSB = 16;
   localparam int WORD_W     = STICKY_LSB + FLAG_COUNT;
   localparam int GAP_W      = STICKY_LSB - FLAG_COUNT;

   typedef enum int {
      FLG_UNDERVOLT = 0,
      FLG_FREQ_CAP  = 1,
      FLG_THROTTLED = 2,
      FLG_SOFT_TEMP = 3
   } flag_idx_e;

   typedef logic [FLAG_COUNT-1:0] flags_t;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
   parameter int W     = 16,
   parameter int LIMIT = 0,
   parameter bit ABOVE = 1'b1
) (
   input  logic [W-1:0] value_i,
   output logic         hit_o
);
   localparam logic [W-1:0] LIM = W'(LIMIT);

   if (W < 1 || W > 31) begin : g_bad_width
      $error("limit_cmp: width out of range");
   end
   if (LIMIT < 0 || LIMIT >= (1 << W)) begin : g_bad_limit
      $error("limit_cmp: limit does not fit the sample width");
   end

   if (ABOVE) begin : g_above
      assign hit_o = (value_i > LIM);
   end else begin : g_below
      assign hit_o = (value_i < LIM);
   end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_i,
   output logic [N-1:0] q_o
);
   if (N < 1) begin : g_bad_n
      $error("sticky_bank: needs at least one bit");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held_q <= 1'b0;
         end else if (clr_i) begin
            held_q <= 1'b0;
         end else begin
            held_q <= held_q | set_i[i];
         end
      end
      assign q_o[i] = held_q;
   end
endmodule

// File: rtl/thermal_status_word.sv
module thermal_status_word
   import thermal_status_pkg::*;
#(
   parameter int VOLT_W        = 16,
   parameter int TEMP_W        = 12,
   parameter int UV_LIMIT_MV   = 4640,
   parameter int CAP_LIMIT_DC  = 800,
   parameter int HOT_LIMIT_DC  = 850,
   parameter int SOFT_LIMIT_DC = 700
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [VOLT_W-1:0] supply_mv,
   input  logic [TEMP_W-1:0] die_temp_dc,
   input  logic              throttle_req,
   input  logic              sticky_clr,
   output logic [WORD_W-1:0] status_word
);
   if (HOT_LIMIT_DC <= CAP_LIMIT_DC) begin : g_bad_order
      $error("thermal_status_word: hot limit must exceed cap limit");
   end

   logic   uv_hit, cap_hit, hot_hit, soft_hit;
   flags_t live_d, live_q, sticky_q;

   limit_cmp #(.W(VOLT_W), .LIMIT(UV_LIMIT_MV), .ABOVE(1'b0)) i_uv_cmp (
      .value_i(supply_mv), .hit_o(uv_hit));
   limit_cmp #(.W(TEMP_W), .LIMIT(CAP_LIMIT_DC), .ABOVE(1'b1)) i_cap_cmp (
      .value_i(die_temp_dc), .hit_o(cap_hit));
   limit_cmp #(.W(TEMP_W), .LIMIT(HOT_LIMIT_DC), .ABOVE(1'b1)) i_hot_cmp (
      .value_i(die_temp_dc), .hit_o(hot_hit));
   limit_cmp #(.W(TEMP_W), .LIMIT(SOFT_LIMIT_DC), .ABOVE(1'b1)) i_soft_cmp (
      .value_i(die_temp_dc), .hit_o(soft_hit));

   always_comb begin
      live_d                = '0;
      live_d[FLG_UNDERVOLT] = uv_hit;
      live_d[FLG_FREQ_CAP]  = cap_hit | hot_hit;
      live_d[FLG_THROTTLED] = throttle_req | hot_hit;
      live_d[FLG_SOFT_TEMP] = soft_hit;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= '0;
      end else begin
         live_q <= live_d;
      end
   end

   sticky_bank #(.N(FLAG_COUNT)) i_sticky (
      .clk(clk), .rst_n(rst_n), .set_i(live_d), .clr_i(sticky_clr), .q_o(sticky_q));

   assign status_word = {sticky_q, {GAP_W{1'b0}}, live_q};
endmodule

// File: rtl/thermal_status_chk.sv
module thermal_status_chk
   import thermal_status_pkg::*;
#(
   parameter int VOLT_W        = 16,
   parameter int TEMP_W        = 12,
   parameter int UV_LIMIT_MV   = 4640,
   parameter int HOT_LIMIT_DC  = 850
) (
   input logic              clk,
   input logic              rst_n,
   input logic [VOLT_W-1:0] supply_mv,
   input logic [TEMP_W-1:0] die_temp_dc,
   input logic              throttle_req,
   input logic              sticky_clr,
   input logic [WORD_W-1:0] status_word
);
   localparam logic [VOLT_W-1:0] UV  = VOLT_W'(UV_LIMIT_MV);
   localparam logic [TEMP_W-1:0] HOT = TEMP_W'(HOT_LIMIT_DC);

   wire [FLAG_COUNT-1:0] live_w   = status_word[FLAG_COUNT-1:0];
   wire [FLAG_COUNT-1:0] sticky_w = status_word[WORD_W-1:STICKY_LSB];
   wire [GAP_W-1:0]      gap_w    = status_word[STICKY_LSB-1:FLAG_COUNT];

   always_comb begin
      if (rst_n) begin
         assert_reserved_zero_R7: assert (gap_w == '0);
      end
   end

   assert_undervolt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_mv < UV) |=> live_w[0]);
   assert_no_undervolt_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (supply_mv >= UV) |=> !live_w[0]);
   assert_throttle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      throttle_req |=> live_w[2]);
   assert_hot_forces_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (die_temp_dc > HOT) |=> (live_w[1] && live_w[2]));
   assert_sticky_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky_clr |=> ((sticky_w & $past(sticky_w)) == $past(sticky_w)));
   assert_live_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !sticky_clr |=> ((live_w & ~sticky_w) == '0));
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      sticky_clr |=> (sticky_w == '0));
endmodule

bind thermal_status_word thermal_status_chk #(
   .VOLT_W(VOLT_W), .TEMP_W(TEMP_W),
   .UV_LIMIT_MV(UV_LIMIT_MV), .HOT_LIMIT_DC(HOT_LIMIT_DC)
) i_chk (
   .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv), .die_temp_dc(die_temp_dc),
   .throttle_req(throttle_req), .sticky_clr(sticky_clr), .status_word(status_word)
);

// File: tb/test_thermal_status_word.sv
module test_thermal_status_word;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] supply_mv = 16'd5000;
   logic [11:0] die_temp_dc = 12'd250;
   logic        throttle_req = 1'b0;
   logic        sticky_clr = 1'b0;
   logic [19:0] status_word;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2 clk = ~clk;

   thermal_status_word i_thermal_status_word (
      .clk(clk), .rst_n(rst_n), .supply_mv(supply_mv), .die_temp_dc(die_temp_dc),
      .throttle_req(throttle_req), .sticky_clr(sticky_clr), .status_word(status_word));

   typedef struct packed {
      logic [15:0] mv;
      logic [11:0] temp;
      logic        thr;
      logic [3:0]  live;  // {soft, throttled, cap, undervolt}
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{16'd5000, 12'd250, 1'b0, 4'b0000},
      '{16'd4640, 12'd250, 1'b0, 4'b0000},  // R2 at limit
      '{16'd4639, 12'd250, 1'b0, 4'b0001},  // R2 below limit
      '{16'd5000, 12'd700, 1'b0, 4'b0000},  // R6 at limit
      '{16'd5000, 12'd701, 1'b0, 4'b1000},  // R6 past limit
      '{16'd5000, 12'd800, 1'b0, 4'b1000},  // R3 at limit
      '{16'd5000, 12'd801, 1'b0, 4'b1010},  // R3 past limit
      '{16'd5000, 12'd850, 1'b0, 4'b1010},  // R5 at hot limit
      '{16'd5000, 12'd851, 1'b0, 4'b1110},  // R5 past hot limit
      '{16'd5000, 12'd300, 1'b1, 4'b0100},  // R4
      '{16'd4000, 12'd900, 1'b1, 4'b1111},
      '{16'd0,    12'd0,   1'b0, 4'b0001}
   };

   task automatic check(input string what, input logic [19:0] act, input logic [19:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %05h expected %05h", what, act, exp);
      end
   endtask

   task automatic drive(input logic [15:0] mv, input logic [11:0] t, input logic thr, input logic clr);
      @(negedge clk);
      supply_mv = mv; die_temp_dc = t; throttle_req = thr; sticky_clr = clr;
      @(posedge clk);
      #1;
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      logic [3:0] sticky_m;
      repeat (3) @(posedge clk);
      #1;
      check("R1 status in reset", status_word, 20'h0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 status after reset", status_word, 20'h0);

      sticky_m = 4'b0;
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i].mv, VECS[i].temp, VECS[i].thr, 1'b0);
         sticky_m = sticky_m | VECS[i].live;
         check($sformatf("R2/R3/R4/R5/R6/R7/R8 vector %0d", i), status_word,
               {sticky_m, 12'h000, VECS[i].live});
      end

      // R8: latched flags survive benign inputs
      drive(16'd5000, 12'd250, 1'b0, 1'b0);
      check("R8 sticky held, live clear", status_word, 20'hF0000);

      // R10: change at negedge, output unchanged before the next edge
      @(negedge clk);
      supply_mv = 16'd4000;
      #1;
      check("R10 no change before edge", status_word, 20'hF0000);
      @(posedge clk); #1;
      check("R10 change after edge", status_word, 20'hF0001);

      // R9: clear with under-voltage still present
      drive(16'd4000, 12'd250, 1'b0, 1'b1);
      check("R9 clear leaves live", status_word, 20'h00001);
      drive(16'd4000, 12'd250, 1'b0, 1'b0);
      check("R9 re-latch next edge", status_word, 20'h10001);
      drive(16'd5000, 12'd250, 1'b0, 1'b1);
      check("R9 clear all", status_word, 20'h00000);
      drive(16'd5000, 12'd250, 1'b0, 1'b0);
      check("R9 stays clear", status_word, 20'h00000);

      // R5 with throttle input low, temperature well above the hot limit
      drive(16'd5000, 12'd4095, 1'b0, 1'b0);
      check("R5 max temp", status_word, 20'hE000E);

      // R1: reset mid-run
      @(negedge clk); rst_n = 1'b0;
      #1;
      check("R1 reset mid-run", status_word, 20'h0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule